// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block records loads that a processor has hoisted above possibly aliasing stores. Each recorded load is keyed by the number of the register it wrote. Every entry keeps the load's byte address, its access size and a small load-type tag. Every store in the machine is snooped against the table, and any store whose bytes touch a recorded range kills that entry without a signal.

When the program reaches the point where the hoisted value is consumed, it issues a check for the same register, address and size. One cycle later the block reports a hit, which means the speculated value is still good, or raises a recovery request, which means the value must be reloaded or the dependent code re-executed.

The table is set-associative. The set is picked by the low bits of the register number. Entries can be evicted under capacity pressure, and an evicted entry can only turn into a miss, never into a false hit. A check may also consume its entry on a hit. A single-cycle clear empties the table.

Top module: `spec_load_table`

## Requirements
- R1: After reset the table holds no entries, `checkDone`, `checkHit` and `recoverReq` are low, and any check then misses.
- R2: A check whose register, address and size all equal those of a recorded load reports `checkHit` high with `checkDone`, in the cycle after `checkValid`. `hitKind` then returns the recorded load type.
- R3: A check misses and raises `recoverReq` when no entry for its register exists, or when the entry's address or size code differs. Size codes are 0, 1, 2 and 3, meaning 1, 2, 4 and 8 bytes.
- R4: A store with byte range [addr, addr+bytes) invalidates every entry whose byte range intersects it. Ranges that only touch end to end leave the entry alone. A check issued in the same cycle as the store still sees the table as it was before that store.
- R5: A new recorded load to a register that already has an entry replaces that entry. A check against the old address then misses, and a check against the new one hits.
- R6: The set is the low 4 bits of the register number, and each set has 4 ways. An allocation fills the lowest free way first. When the set is full, it evicts the way named by a per-set round-robin pointer that starts at way 0 after reset and advances by one per eviction. Checks of evicted registers miss.
- R7: When a store and an allocation arrive in the same cycle, the store is applied first, so the new entry survives even if its range overlaps the store.
- R8: A check with `checkClear` high removes the entry it hits, so a second identical check misses. If an allocation to the same register arrives in that same cycle, the new entry is kept.
- R9: `flushAll` empties the whole table in one cycle and discards an allocation presented in the same cycle.
- R10: `checkDone` is high exactly in the cycle after a `checkValid` cycle. `checkHit` and `recoverReq` are never high together, and both are low whenever `checkDone` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| flushAll | input | 1 | Invalidate every entry |
| allocValid | input | 1 | Record a hoisted load this cycle |
| allocReg | input | 7 | Destination register of the recorded load |
| allocSize | input | 2 | Size code of the recorded load |
| allocKind | input | 2 | Load-type tag to store |
| allocAddr | input | 32 | Byte address of the recorded load |
| storeValid | input | 1 | Store snoop strobe |
| storeAddr | input | 32 | Store byte address |
| storeSize | input | 2 | Store size code |
| checkValid | input | 1 | Check request strobe |
| checkClear | input | 1 | Remove the entry on a hit |
| checkReg | input | 7 | Register being checked |
| checkAddr | input | 32 | Address being checked |
| checkSize | input | 2 | Size code being checked |
| checkDone | output | 1 | Check result valid |
| checkHit | output | 1 | Speculation still valid |
| recoverReq | output | 1 | Speculation lost; recovery needed |
| hitKind | output | 2 | Load-type tag of the hit entry |

## Verification
The check path is exercised with exact matches and with near-misses that differ only in register, address or size, so that each compare field is shown to matter on its own. Stores are aimed at the bytes just below, just above and on the last byte of a recorded range; this separates a correct half-open overlap test from one that is off by one. Five and then six registers mapped to one set show the lowest-free fill order and the round-robin victim sequence. Same-cycle pairs, namely store with allocation, flush with allocation, check with store, and check-clear with reallocation, pin down the ordering rules.

// File: rtl/slt_pkg.sv
package slt_pkg;
  parameter int SETS   = 16;
  parameter int WAYS   = 4;
  parameter int REG_W  = 7;
  parameter int ADDR_W = 32;
  parameter int KIND_W = 2;
  parameter int SIZE_W = 2;

  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  typedef logic [SIZE_W-1:0] sizeCode_t;

  // Strobes from control to the entry storage
  typedef struct packed {
    logic             flush;
    logic             write;
    logic [SET_W-1:0] wrSet;
    logic [WAY_W-1:0] wrWay;
    logic             snoop;
    logic             kill;
    logic [SET_W-1:0] killSet;
    logic [WAY_W-1:0] killWay;
  } tableCmd_t;

  // Exclusive end of a byte range, one bit wider than an address
  function automatic logic [ADDR_W:0] spanEnd(input logic [ADDR_W-1:0] base,
                                              input sizeCode_t code);
    logic [ADDR_W:0] bytes;
    bytes = (ADDR_W+1)'(1) << code;
    return {1'b0, base} + bytes;
  endfunction

  function automatic logic [WAY_W-1:0] wayIndex(input logic [WAYS-1:0] oneHot);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < WAYS; i++)
      if (oneHot[i]) idx = idx | WAY_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/slt_data.sv
module slt_data import slt_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  tableCmd_t         cmd,
  input  logic [REG_W-1:0]  allocReg,
  input  sizeCode_t         allocSize,
  input  logic [KIND_W-1:0] allocKind,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic [ADDR_W-1:0] storeAddr,
  input  sizeCode_t         storeSize,
  input  logic [REG_W-1:0]  checkReg,
  input  logic [ADDR_W-1:0] checkAddr,
  input  sizeCode_t         checkSize,
  output logic [WAYS-1:0]   allocSame,
  output logic [WAYS-1:0]   allocFree,
  output logic [WAYS-1:0]   checkWays,
  output logic [KIND_W-1:0] checkKind
);
  logic [SETS-1:0][WAYS-1:0] entValid;
  logic [REG_W-1:0]  entReg  [SETS][WAYS];
  logic [ADDR_W-1:0] entAddr [SETS][WAYS];
  sizeCode_t         entSize [SETS][WAYS];
  logic [KIND_W-1:0] entKind [SETS][WAYS];

  logic [SETS-1:0][WAYS-1:0] snoopHit;
  logic [ADDR_W:0]           storeEnd;
  logic [SET_W-1:0]          aSet, cSet;

  assign storeEnd = spanEnd(storeAddr, storeSize);
  assign aSet     = allocReg[SET_W-1:0];
  assign cSet     = checkReg[SET_W-1:0];

  // Per-entry byte-range intersection with the snooped store
  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [ADDR_W:0] entEnd;
      assign entEnd = spanEnd(entAddr[s][w], entSize[s][w]);
      assign snoopHit[s][w] = ({1'b0, entAddr[s][w]} < storeEnd) &&
                              ({1'b0, storeAddr} < entEnd);
    end
  end

  // Set lookups for allocation and check
  always_comb begin
    checkKind = '0;
    for (int w = 0; w < WAYS; w++) begin
      allocSame[w] = entValid[aSet][w] && (entReg[aSet][w] == allocReg);
      allocFree[w] = !entValid[aSet][w];
      checkWays[w] = entValid[cSet][w] && (entReg[cSet][w] == checkReg) &&
                     (entAddr[cSet][w] == checkAddr) && (entSize[cSet][w] == checkSize);
      if (checkWays[w]) checkKind = checkKind | entKind[cSet][w];
    end
  end

  // Valid bits: flush, then store kill, then check kill, then write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
    end else if (cmd.flush) begin
      entValid <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (cmd.snoop && snoopHit[s][w]) entValid[s][w] <= 1'b0;
          if (cmd.kill && cmd.killSet == SET_W'(s) && cmd.killWay == WAY_W'(w))
            entValid[s][w] <= 1'b0;
          if (cmd.write && cmd.wrSet == SET_W'(s) && cmd.wrWay == WAY_W'(w))
            entValid[s][w] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.write) begin
      entReg [cmd.wrSet][cmd.wrWay] <= allocReg;
      entAddr[cmd.wrSet][cmd.wrWay] <= allocAddr;
      entSize[cmd.wrSet][cmd.wrWay] <= allocSize;
      entKind[cmd.wrSet][cmd.wrWay] <= allocKind;
    end
  end
endmodule

// File: rtl/slt_ctrl.sv
module slt_ctrl import slt_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              allocValid,
  input  logic [SET_W-1:0]  allocSet,
  input  logic              storeValid,
  input  logic              checkValid,
  input  logic              checkClear,
  input  logic [SET_W-1:0]  checkSet,
  input  logic [WAYS-1:0]   allocSame,
  input  logic [WAYS-1:0]   allocFree,
  input  logic [WAYS-1:0]   checkWays,
  input  logic [KIND_W-1:0] checkKind,
  output tableCmd_t         cmd,
  output logic              checkDone,
  output logic              checkHit,
  output logic              recoverReq,
  output logic [KIND_W-1:0] hitKind
);
  logic [SETS-1:0][WAY_W-1:0] rrPtr;
  logic [WAY_W-1:0]           victim;
  logic                       takeRr;
  logic                       anyMatch;

  assign anyMatch = |checkWays;

  // Way choice: same register, else lowest free, else round-robin
  always_comb begin
    victim = rrPtr[allocSet];
    takeRr = 1'b1;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (allocFree[w]) begin
        victim = WAY_W'(w);
        takeRr = 1'b0;
      end
    end
    if (|allocSame) begin
      victim = wayIndex(allocSame);
      takeRr = 1'b0;
    end
  end

  always_comb begin
    cmd.flush   = flushAll;
    cmd.write   = allocValid && !flushAll;
    cmd.wrSet   = allocSet;
    cmd.wrWay   = victim;
    cmd.snoop   = storeValid;
    cmd.kill    = checkValid && checkClear && anyMatch;
    cmd.killSet = checkSet;
    cmd.killWay = wayIndex(checkWays);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (cmd.write && takeRr) begin
      rrPtr[allocSet] <= rrPtr[allocSet] + WAY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      checkDone  <= 1'b0;
      checkHit   <= 1'b0;
      recoverReq <= 1'b0;
      hitKind    <= '0;
    end else begin
      checkDone  <= checkValid;
      checkHit   <= checkValid && anyMatch;
      recoverReq <= checkValid && !anyMatch;
      hitKind    <= (checkValid && anyMatch) ? checkKind : '0;
    end
  end
endmodule

// File: rtl/spec_load_table.sv
module spec_load_table import slt_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              allocValid,
  input  logic [REG_W-1:0]  allocReg,
  input  logic [SIZE_W-1:0] allocSize,
  input  logic [KIND_W-1:0] allocKind,
  input  logic [ADDR_W-1:0] allocAddr,
  input  logic              storeValid,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [SIZE_W-1:0] storeSize,
  input  logic              checkValid,
  input  logic              checkClear,
  input  logic [REG_W-1:0]  checkReg,
  input  logic [ADDR_W-1:0] checkAddr,
  input  logic [SIZE_W-1:0] checkSize,
  output logic              checkDone,
  output logic              checkHit,
  output logic              recoverReq,
  output logic [KIND_W-1:0] hitKind
);
  tableCmd_t         cmd;
  logic [WAYS-1:0]   allocSame, allocFree, checkWays;
  logic [KIND_W-1:0] checkKind;

  slt_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flushAll   (flushAll),
    .allocValid (allocValid),
    .allocSet   (allocReg[SET_W-1:0]),
    .storeValid (storeValid),
    .checkValid (checkValid),
    .checkClear (checkClear),
    .checkSet   (checkReg[SET_W-1:0]),
    .allocSame  (allocSame),
    .allocFree  (allocFree),
    .checkWays  (checkWays),
    .checkKind  (checkKind),
    .cmd        (cmd),
    .checkDone  (checkDone),
    .checkHit   (checkHit),
    .recoverReq (recoverReq),
    .hitKind    (hitKind)
  );

  slt_data i_data (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .allocReg  (allocReg),
    .allocSize (allocSize),
    .allocKind (allocKind),
    .allocAddr (allocAddr),
    .storeAddr (storeAddr),
    .storeSize (storeSize),
    .checkReg  (checkReg),
    .checkAddr (checkAddr),
    .checkSize (checkSize),
    .allocSame (allocSame),
    .allocFree (allocFree),
    .checkWays (checkWays),
    .checkKind (checkKind)
  );
endmodule

// File: rtl/slt_checker.sv
module slt_checker (
  input logic clk,
  input logic rstN,
  input logic flushAll,
  input logic allocValid,
  input logic checkValid,
  input logic checkDone,
  input logic checkHit,
  input logic recoverReq
);
  // Table known empty: set by reset or flush, cleared by any allocation
  logic emptyQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           emptyQ <= 1'b1;
    else if (flushAll)   emptyQ <= 1'b1;
    else if (allocValid) emptyQ <= 1'b0;
  end

  assert_done_follows_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    checkValid |=> checkDone);

  assert_done_needs_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> !checkDone);

  assert_result_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(checkHit && recoverReq));

  assert_miss_raises_recovery_R3: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |-> (checkHit != recoverReq));

  assert_empty_never_hits_R9: assert property (@(posedge clk) disable iff (!rstN)
    (checkDone && $past(emptyQ)) |-> !checkHit);
endmodule

bind spec_load_table slt_checker i_checker (
  .clk        (clk),
  .rstN       (rstN),
  .flushAll   (flushAll),
  .allocValid (allocValid),
  .checkValid (checkValid),
  .checkDone  (checkDone),
  .checkHit   (checkHit),
  .recoverReq (recoverReq)
);

// File: tb/test_spec_load_table.sv
module test_spec_load_table;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushAll, allocValid, storeValid, checkValid, checkClear;
  logic [6:0]  allocReg, checkReg;
  logic [1:0]  allocSize, allocKind, storeSize, checkSize;
  logic [31:0] allocAddr, storeAddr, checkAddr;
  logic        checkDone, checkHit, recoverReq;
  logic [1:0]  hitKind;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  spec_load_table i_spec_load_table (.*);

  localparam logic [2:0] OA = 3'd0, OS = 3'd1, OC = 3'd2, OK = 3'd3, OF = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [6:0]  rg;
    logic [31:0] addr;
    logic [1:0]  sz;
    logic [1:0]  kind;
    logic        expHit;
    logic [1:0]  expKind;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    {OC, 7'd5,  32'h100,  2'd2, 2'd0, 1'b0, 2'd0, 8'd1},  // R1 empty table misses
    {OA, 7'd5,  32'h100,  2'd2, 2'd1, 1'b0, 2'd0, 8'd2},
    {OC, 7'd5,  32'h100,  2'd2, 2'd0, 1'b1, 2'd1, 8'd2},  // R2 exact hit, kind 1
    {OC, 7'd5,  32'h104,  2'd2, 2'd0, 1'b0, 2'd0, 8'd3},  // R3 address differs
    {OC, 7'd5,  32'h100,  2'd1, 2'd0, 1'b0, 2'd0, 8'd3},  // R3 size differs
    {OC, 7'd6,  32'h100,  2'd2, 2'd0, 1'b0, 2'd0, 8'd3},  // R3 register differs
    {OS, 7'd0,  32'h104,  2'd3, 2'd0, 1'b0, 2'd0, 8'd4},  // R4 touches from above
    {OS, 7'd0,  32'h0FC,  2'd2, 2'd0, 1'b0, 2'd0, 8'd4},  // R4 touches from below
    {OC, 7'd5,  32'h100,  2'd2, 2'd0, 1'b1, 2'd1, 8'd4},  // R4 adjacent stores kept it
    {OS, 7'd0,  32'h103,  2'd0, 2'd0, 1'b0, 2'd0, 8'd4},  // R4 last byte overlap
    {OC, 7'd5,  32'h100,  2'd2, 2'd0, 1'b0, 2'd0, 8'd4},  // R4 killed
    {OA, 7'd7,  32'h200,  2'd3, 2'd2, 1'b0, 2'd0, 8'd5},
    {OA, 7'd7,  32'h300,  2'd0, 2'd3, 1'b0, 2'd0, 8'd5},
    {OC, 7'd7,  32'h200,  2'd3, 2'd0, 1'b0, 2'd0, 8'd5},  // R5 old record gone
    {OC, 7'd7,  32'h300,  2'd0, 2'd0, 1'b1, 2'd3, 8'd5},  // R5 new record hits
    {OA, 7'd1,  32'h1000, 2'd2, 2'd0, 1'b0, 2'd0, 8'd6},
    {OA, 7'd17, 32'h1010, 2'd2, 2'd0, 1'b0, 2'd0, 8'd6},
    {OA, 7'd33, 32'h1020, 2'd2, 2'd0, 1'b0, 2'd0, 8'd6},
    {OA, 7'd49, 32'h1030, 2'd2, 2'd0, 1'b0, 2'd0, 8'd6},
    {OA, 7'd65, 32'h1040, 2'd2, 2'd1, 1'b0, 2'd0, 8'd6},  // R6 evicts way 0
    {OC, 7'd1,  32'h1000, 2'd2, 2'd0, 1'b0, 2'd0, 8'd6},  // R6 reg 1 evicted
    {OC, 7'd17, 32'h1010, 2'd2, 2'd0, 1'b1, 2'd0, 8'd6},
    {OC, 7'd65, 32'h1040, 2'd2, 2'd0, 1'b1, 2'd1, 8'd6},
    {OA, 7'd81, 32'h1050, 2'd2, 2'd2, 1'b0, 2'd0, 8'd6},  // R6 evicts way 1
    {OC, 7'd17, 32'h1010, 2'd2, 2'd0, 1'b0, 2'd0, 8'd6},  // R6 reg 17 evicted
    {OC, 7'd33, 32'h1020, 2'd2, 2'd0, 1'b1, 2'd0, 8'd6},
    {OC, 7'd81, 32'h1050, 2'd2, 2'd0, 1'b1, 2'd2, 8'd6},
    {OA, 7'd9,  32'h400,  2'd1, 2'd1, 1'b0, 2'd0, 8'd8},
    {OK, 7'd9,  32'h400,  2'd1, 2'd0, 1'b1, 2'd1, 8'd8},  // R8 consuming hit
    {OC, 7'd9,  32'h400,  2'd1, 2'd0, 1'b0, 2'd0, 8'd8},  // R8 entry consumed
    {OK, 7'd10, 32'h500,  2'd1, 2'd0, 1'b0, 2'd0, 8'd8},  // R8 clear on a miss
    {OF, 7'd0,  32'h0,    2'd0, 2'd0, 1'b0, 2'd0, 8'd9},
    {OC, 7'd7,  32'h300,  2'd0, 2'd0, 1'b0, 2'd0, 8'd9},  // R9 flushed
    {OC, 7'd33, 32'h1020, 2'd2, 2'd0, 1'b0, 2'd0, 8'd9}   // R9 flushed
  };

  task automatic idleInputs();
    flushAll = 0; allocValid = 0; storeValid = 0; checkValid = 0; checkClear = 0;
    allocReg = '0; allocSize = '0; allocKind = '0; allocAddr = '0;
    storeAddr = '0; storeSize = '0; checkReg = '0; checkAddr = '0; checkSize = '0;
  endtask

  task automatic driveCheck(input logic [6:0] r, input logic [31:0] a, input logic [1:0] s,
                            input logic clr);
    checkValid = 1; checkClear = clr; checkReg = r; checkAddr = a; checkSize = s;
  endtask

  task automatic expectResult(input logic expHit, input logic [1:0] expKind, input int req,
                              input string what);
    checks++;
    if (checkDone !== 1'b1 || checkHit !== expHit || recoverReq !== !expHit ||
        (expHit && hitKind !== expKind)) begin
      fails++;
      $display("FAIL R%0d %s: done=%b hit=%b recover=%b kind=%0d, expected done=1 hit=%b recover=%b kind=%0d",
               req, what, checkDone, checkHit, recoverReq, hitKind, expHit, !expHit, expKind);
    end
  endtask

  task automatic expectQuiet(input int req, input string what);
    checks++;
    if (checkDone !== 1'b0 || checkHit !== 1'b0 || recoverReq !== 1'b0) begin
      fails++;
      $display("FAIL R%0d %s: done=%b hit=%b recover=%b, expected all 0",
               req, what, checkDone, checkHit, recoverReq);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    vec_t v;
    idleInputs();
    repeat (3) @(negedge clk);
    expectQuiet(1, "outputs during reset");              // R1
    rstN = 1'b1;
    @(negedge clk);
    expectQuiet(1, "outputs after reset");               // R1

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      case (v.op)
        OA: begin allocValid = 1; allocReg = v.rg; allocAddr = v.addr;
                  allocSize = v.sz; allocKind = v.kind; end
        OS: begin storeValid = 1; storeAddr = v.addr; storeSize = v.sz; end
        OC: driveCheck(v.rg, v.addr, v.sz, 1'b0);
        OK: driveCheck(v.rg, v.addr, v.sz, 1'b1);
        default: flushAll = 1;
      endcase
      @(negedge clk);
      idleInputs();
      if (v.op == OC || v.op == OK) expectResult(v.expHit, v.expKind, int'(v.req), "table vector");
    end

    // R10 no check in the previous cycle: all result outputs low
    @(negedge clk);
    expectQuiet(10, "idle cycle");

    // R7 store and allocation in one cycle, overlapping: entry survives
    allocValid = 1; allocReg = 7'd20; allocAddr = 32'h600; allocSize = 2'd2; allocKind = 2'd2;
    storeValid = 1; storeAddr = 32'h600; storeSize = 2'd3;
    @(negedge clk); idleInputs();
    driveCheck(7'd20, 32'h600, 2'd2, 1'b0);
    @(negedge clk); idleInputs();
    expectResult(1'b1, 2'd2, 7, "alloc survives same-cycle store");

    // R4 check alongside an overlapping store sees the prior table
    driveCheck(7'd20, 32'h600, 2'd2, 1'b0);
    storeValid = 1; storeAddr = 32'h602; storeSize = 2'd0;
    @(negedge clk); idleInputs();
    expectResult(1'b1, 2'd2, 4, "check beside store");
    driveCheck(7'd20, 32'h600, 2'd2, 1'b0);
    @(negedge clk); idleInputs();
    expectResult(1'b0, 2'd0, 4, "store took effect after edge");

    // R9 flush discards an allocation in the same cycle
    flushAll = 1; allocValid = 1; allocReg = 7'd21; allocAddr = 32'h700;
    allocSize = 2'd0; allocKind = 2'd1;
    @(negedge clk); idleInputs();
    driveCheck(7'd21, 32'h700, 2'd0, 1'b0);
    @(negedge clk); idleInputs();
    expectResult(1'b0, 2'd0, 9, "flush beats alloc");

    // R8 consuming check and reallocation of the same register together
    allocValid = 1; allocReg = 7'd22; allocAddr = 32'h800; allocSize = 2'd2; allocKind = 2'd0;
    @(negedge clk); idleInputs();
    driveCheck(7'd22, 32'h800, 2'd2, 1'b1);
    allocValid = 1; allocReg = 7'd22; allocAddr = 32'h810; allocSize = 2'd2; allocKind = 2'd1;
    @(negedge clk); idleInputs();
    expectResult(1'b1, 2'd0, 8, "consuming hit with realloc");
    driveCheck(7'd22, 32'h810, 2'd2, 1'b0);
    @(negedge clk); idleInputs();
    expectResult(1'b1, 2'd1, 8, "realloc kept over consume");

    finishRun();
  end
endmodule